// File: doc/BRIEF.md
# One-Bit FIR Decimator

This block turns the single-bit stream from a delta-sigma modulator into signed multi-bit samples at a lower rate. Each accepted bit enters a tap line. Every tap gates one fixed coefficient. A tap holding a one contributes the coefficient. A tap holding a zero contributes nothing in unipolar mode, or the negated coefficient in bipolar mode. All contributions are added in a registered adder tree. Only one sum out of every `DECIM` accepted bits leaves the block, with a one-cycle valid pulse.

The coefficients are set by a packed parameter vector, with tap k in bits `[k*COEF_W +: COEF_W]`. They are read as signed two's complement. A bit counts as accepted only on a clock where the bit strobe is high. Between strobes the block keeps its state, so the modulator may run slower than the system clock. A zero-volt modulator input shows up as alternating ones and zeros. In bipolar mode, with coefficients whose even-age sum equals their odd-age sum, that pattern produces a sum of exactly zero.

Top module: `onebit_fir_decim`

## Requirements
- R1: While `rst` is high, and after it is released until the first sample, `sample_vld_o` is 0 and `sample_o` is 0.
- R2: The tap line shifts only on clocks with `bit_vld_i` high. Coefficient k is applied to the bit accepted k strobes before the newest one, with k = 0 for the newest bit.
- R3: With `bipolar_i` = 0, a sample equals the sum of the coefficients whose tap holds 1.
- R4: With `bipolar_i` = 1, a tap holding 1 adds its coefficient and a tap holding 0 subtracts it. The result is two's complement.
- R5: A sample is produced for accepted-bit counts since reset that are multiples of `DECIM`. The other strobes produce no output.
- R6: No sample is produced until `NTAPS` bits have been accepted since the last reset.
- R7: `sample_vld_o` is a one-cycle pulse. It is high after the rising edge that comes `$clog2(NTAPS)+2` edges after the edge that accepted the completing bit.
- R8: `sample_o` holds its value between valid pulses.
- R9: `sample_o` is `COEF_W+$clog2(NTAPS)+1` bits wide. It is exact for any coefficient set, including every coefficient at the most negative code in bipolar mode.
- R10: In bipolar mode, an alternating 1/0 input with pairwise-equal neighbouring coefficients yields a sample of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_i | input | 1 | Modulator bit, 1 = positive reference |
| bit_vld_i | input | 1 | Strobe: accept `bit_i` this clock |
| bipolar_i | input | 1 | 1 = zero bits subtract their coefficient |
| sample_o | output | ACC_W | Signed decimated sample |
| sample_vld_o | output | 1 | One-cycle pulse marking a new sample |

## Verification
The hardest situation to reach from the ports is a decimation boundary that falls before the tap line is full. The bench instance uses more taps than the decimation ratio, so the first two boundaries after each reset must be suppressed. The bench reaches this both after the power-on reset and after a reset issued in the middle of a stream. Overflow headroom is exercised by placing the most negative coefficient code on two taps and feeding long runs of zeros in bipolar mode. Irregular strobe gaps then check that the decimation phase counts accepted bits rather than clocks.

// File: rtl/ofd_pkg.sv
package ofd_pkg;

  localparam int DEF_TAPS = 32;
  localparam int DEF_CW   = 12;

  function automatic int acc_width(input int cw, input int ntaps);
    return cw + $clog2(ntaps) + 1;
  endfunction

  // triangular default response, peak 1600 fits a 12-bit signed code
  function automatic logic [DEF_TAPS*DEF_CW-1:0] tri_coefs();
    logic [DEF_TAPS*DEF_CW-1:0] v;
    int h;
    v = '0;
    for (int i = 0; i < DEF_TAPS; i++) begin
      h = (i < DEF_TAPS / 2) ? (i + 1) : (DEF_TAPS - i);
      v[i*DEF_CW +: DEF_CW] = DEF_CW'(h * 100);
    end
    return v;
  endfunction

endpackage

// File: rtl/ofd_tap_line.sv
module ofd_tap_line #(
  parameter int NTAPS = 32,
  localparam int CNTW = $clog2(NTAPS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_i,
  input  logic             shift_i,
  output logic [NTAPS-1:0] taps_o,
  output logic             near_full_o,
  output logic             full_o
);

  logic [NTAPS-1:0] taps_q;
  logic [CNTW-1:0]  fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      taps_q <= '0;
      fill_q <= '0;
    end else if (shift_i) begin
      taps_q <= {taps_q[NTAPS-2:0], bit_i};
      if (fill_q != CNTW'(NTAPS)) fill_q <= fill_q + 1'b1;
    end
  end

  assign taps_o      = taps_q;
  assign near_full_o = (fill_q >= CNTW'(NTAPS - 1));
  assign full_o      = (fill_q == CNTW'(NTAPS));

  // R2: no strobe, no movement of the line
  a_r2_taps_hold: assert property (@(posedge clk) disable iff (rst)
    !shift_i |=> $stable(taps_q));

endmodule

// File: rtl/ofd_phase.sv
module ofd_phase #(
  parameter int DECIM = 128,
  localparam int PW = (DECIM > 1) ? $clog2(DECIM) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic ready_i,
  output logic pick_o
);

  logic [PW-1:0] ph_q;
  logic          pick_q;
  logic          wrap;

  assign wrap = (ph_q == PW'(DECIM - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= '0;
      pick_q <= 1'b0;
    end else begin
      pick_q <= tick_i && wrap && ready_i;
      if (tick_i) ph_q <= wrap ? '0 : ph_q + 1'b1;
    end
  end

  assign pick_o = pick_q;

  // R5: boundaries are at least one strobe apart, so a pick never repeats
  a_r5_single_pick: assert property (@(posedge clk) disable iff (rst)
    pick_q |=> !pick_q);

endmodule

// File: rtl/ofd_gate.sv
module ofd_gate #(
  parameter int NTAPS = 32,
  parameter int COEF_W = 12,
  parameter int ACC_W = 18,
  parameter logic [NTAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NTAPS-1:0]            taps_i,
  input  logic                        bipolar_i,
  input  logic                        vld_i,
  output logic [NTAPS-1:0][ACC_W-1:0] terms_o,
  output logic                        vld_o
);

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    localparam logic signed [COEF_W-1:0] C  = COEFS[i*COEF_W +: COEF_W];
    localparam logic signed [ACC_W-1:0]  CP = ACC_W'(C);
    localparam logic signed [ACC_W-1:0]  CN = -CP;
    always_ff @(posedge clk) begin
      if (taps_i[i])      terms_o[i] <= CP;
      else if (bipolar_i) terms_o[i] <= CN;
      else                terms_o[i] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
  end

endmodule

// File: rtl/ofd_tree.sv
module ofd_tree #(
  parameter int NLEAF = 32,
  parameter int W = 18,
  localparam int L = $clog2(NLEAF),
  localparam int P = 1 << L
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NLEAF-1:0][W-1:0] leaves_i,
  input  logic                    vld_i,
  output logic [W-1:0]            root_o,
  output logic                    vld_o
);

  for (genvar l = 0; l <= L; l++) begin : lv
    logic [(P>>l)*W-1:0] v;
    if (l == 0) begin : g_in
      for (genvar j = 0; j < P; j++) begin : g_pad
        if (j < NLEAF) begin : g_use
          assign v[j*W +: W] = leaves_i[j];
        end else begin : g_zero
          assign v[j*W +: W] = '0;
        end
      end
    end else begin : g_add
      for (genvar j = 0; j < (P >> l); j++) begin : g_node
        always_ff @(posedge clk) begin
          v[j*W +: W] <= $signed(lv[l-1].v[(2*j)*W +: W])
                       + $signed(lv[l-1].v[(2*j+1)*W +: W]);
        end
      end
    end
  end

  logic [L-1:0] vp_q;

  always_ff @(posedge clk) begin
    if (rst) vp_q <= '0;
    else begin
      vp_q[0] <= vld_i;
      for (int k = 1; k < L; k++) vp_q[k] <= vp_q[k-1];
    end
  end

  assign root_o = lv[L].v[W-1:0];
  assign vld_o  = vp_q[L-1];

endmodule

// File: rtl/onebit_fir_decim.sv
module onebit_fir_decim #(
  parameter int NTAPS  = ofd_pkg::DEF_TAPS,
  parameter int COEF_W = ofd_pkg::DEF_CW,
  parameter int DECIM  = 128,
  parameter logic [NTAPS*COEF_W-1:0] COEFS = ofd_pkg::tri_coefs(),
  localparam int ACC_W = ofd_pkg::acc_width(COEF_W, NTAPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bit_i,
  input  logic                    bit_vld_i,
  input  logic                    bipolar_i,
  output logic signed [ACC_W-1:0] sample_o,
  output logic                    sample_vld_o
);

  function automatic longint abs_sum();
    longint s;
    longint c;
    s = 0;
    for (int i = 0; i < NTAPS; i++) begin
      c = longint'($signed(COEFS[i*COEF_W +: COEF_W]));
      s += (c < 0) ? -c : c;
    end
    return s;
  endfunction

  localparam longint SUM_ABS = abs_sum();

  logic [NTAPS-1:0]            taps;
  logic                        near_full, full;
  logic                        pick;
  logic [NTAPS-1:0][ACC_W-1:0] terms;
  logic                        terms_vld;
  logic [ACC_W-1:0]            root;
  logic                        root_vld;

  ofd_tap_line #(.NTAPS(NTAPS)) u_line (
    .clk(clk), .rst(rst), .bit_i(bit_i), .shift_i(bit_vld_i),
    .taps_o(taps), .near_full_o(near_full), .full_o(full)
  );

  ofd_phase #(.DECIM(DECIM)) u_phase (
    .clk(clk), .rst(rst), .tick_i(bit_vld_i), .ready_i(near_full),
    .pick_o(pick)
  );

  ofd_gate #(.NTAPS(NTAPS), .COEF_W(COEF_W), .ACC_W(ACC_W), .COEFS(COEFS)) u_gate (
    .clk(clk), .rst(rst), .taps_i(taps), .bipolar_i(bipolar_i),
    .vld_i(pick), .terms_o(terms), .vld_o(terms_vld)
  );

  ofd_tree #(.NLEAF(NTAPS), .W(ACC_W)) u_tree (
    .clk(clk), .rst(rst), .leaves_i(terms), .vld_i(terms_vld),
    .root_o(root), .vld_o(root_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o     <= '0;
      sample_vld_o <= 1'b0;
    end else begin
      sample_vld_o <= root_vld;
      if (root_vld) sample_o <= $signed(root);
    end
  end

  // R6: an output pulse implies the line has been filled since reset
  a_r6_valid_after_fill: assert property (@(posedge clk) disable iff (rst)
    sample_vld_o |-> full);

  // R8: the sample register moves only when the tree delivers a sum
  a_r8_sample_hold: assert property (@(posedge clk) disable iff (rst)
    !root_vld |=> $stable(sample_o));

  // R9: the tree result never leaves the coefficient-magnitude bound
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    root_vld |-> (longint'($signed(root)) <= SUM_ABS &&
                  longint'($signed(root)) >= -SUM_ABS));

endmodule

// File: tb/onebit_fir_decim_tb_top.sv
module onebit_fir_decim_tb_top;

  localparam int NT  = 20;
  localparam int CW  = 10;
  localparam int DC  = 8;
  localparam int LAT = $clog2(NT) + 2;
  localparam int AW  = CW + $clog2(NT) + 1;

  // neighbouring taps share a value; pair 0 holds the most negative code
  function automatic int cf(input int i);
    int k;
    k = i / 2;
    if (k == 0) return -512;
    if (k == 9) return 511;
    return ((k * 149 + 7) % 1024) - 512;
  endfunction

  function automatic logic [NT*CW-1:0] pack_coefs();
    logic [NT*CW-1:0] v;
    for (int i = 0; i < NT; i++) v[i*CW +: CW] = CW'(cf(i));
    return v;
  endfunction

  function automatic longint csum();
    longint s;
    s = 0;
    for (int i = 0; i < NT; i++) s += cf(i);
    return s;
  endfunction

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bin = 1'b0;
  logic bvld = 1'b0;
  logic mode = 1'b0;
  logic signed [AW-1:0] sample;
  logic svld;

  always #2 clk = ~clk;

  onebit_fir_decim #(.NTAPS(NT), .COEF_W(CW), .DECIM(DC), .COEFS(pack_coefs())) dut_i (
    .clk(clk), .rst(rst), .bit_i(bin), .bit_vld_i(bvld), .bipolar_i(mode),
    .sample_o(sample), .sample_vld_o(svld)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int nstrobe = 0;
  int vcount = 0;
  bit hist[$];
  int due[$];
  longint expv[$];
  longint last_val = 0;
  string tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // reference model: bit history and scheduled outputs
  always @(posedge clk) begin
    longint s;
    cyc++;
    if (rst) begin
      hist.delete();
      due.delete();
      expv.delete();
      nstrobe = 0;
    end else if (bvld) begin
      hist.push_front(bin);
      if (hist.size() > NT) void'(hist.pop_back());
      nstrobe++;
      if (nstrobe % DC == 0 && nstrobe >= NT) begin
        s = 0;
        for (int k = 0; k < NT; k++) begin
          if (hist[k]) s += cf(k);
          else if (mode) s -= cf(k);
        end
        due.push_back(cyc + LAT);
        expv.push_back(s);
      end
    end
  end

  // comparison on every clock, away from the active edge
  always @(negedge clk) begin
    bit exp_v;
    longint ev;
    if (cyc > 0) begin
      if (rst) begin
        chk(svld == 1'b0, "R1", longint'(svld), 0);
        chk(sample == '0, "R1", longint'(sample), 0);
        last_val = 0;
      end else begin
        exp_v = (due.size() > 0) && (due[0] == cyc);
        chk(svld == exp_v, (nstrobe < NT) ? "R6" : "R5,R7", longint'(svld), longint'(exp_v));
        if (exp_v) begin
          ev = expv[0];
          void'(due.pop_front());
          void'(expv.pop_front());
          chk(longint'(sample) == ev, tag, longint'(sample), ev);
        end else begin
          chk(longint'(sample) == last_val, "R8", longint'(sample), last_val);
        end
        if (svld) vcount++;
        last_val = longint'(sample);
      end
    end
  end

  function automatic logic next_bit(input int kind, input int idx);
    case (kind)
      1: return 1'b1;
      2: return 1'b0;
      3: return idx[0];
      default: return lfsr[0];
    endcase
  endfunction

  task automatic feed(input int n, input int kind, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      bin  = next_bit(kind, i);
      bvld = 1'b1;
      if (gaps && lfsr[3]) begin
        @(negedge clk);
        bvld = 1'b0;
        if (lfsr[5]) begin
          @(negedge clk);
        end
      end
    end
    @(negedge clk);
    bvld = 1'b0;
  endtask

  task automatic drain();
    repeat (LAT + 4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(svld == 1'b0 && sample == '0, "R1", longint'(sample), 0);

    // R6: two decimation boundaries fall before the line is full
    tag = "R6";
    feed(NT + 3, 0, 1'b0);
    drain();
    chk(vcount == 0, "R6", vcount, 0);
    feed(1, 0, 1'b0);
    drain();
    chk(vcount == 1, "R6", vcount, 1);

    // R3, R2: unipolar random data, continuous and with strobe gaps
    tag = "R3";
    feed(80, 0, 1'b0);
    feed(64, 0, 1'b1);
    feed(40, 1, 1'b0);
    drain();
    chk(last_val == csum(), "R3", last_val, csum());
    feed(40, 2, 1'b1);
    drain();
    chk(last_val == 0, "R3", last_val, 0);

    // R4: bipolar random data
    @(negedge clk);
    mode = 1'b1;
    tag = "R4";
    feed(88, 0, 1'b1);
    drain();

    // R9: all zeros in bipolar mode drives the sum to minus the total
    tag = "R9";
    feed(40, 2, 1'b0);
    drain();
    chk(last_val == -csum(), "R9", last_val, -csum());
    feed(40, 1, 1'b1);
    drain();
    chk(last_val == csum(), "R9", last_val, csum());

    // R10: alternating input averages to zero
    tag = "R10";
    feed(48, 3, 1'b0);
    drain();
    chk(last_val == 0, "R10", last_val, 0);

    // R6: reset in mid-stream restarts the fill holdback
    feed(5, 0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    vcount = 0;
    tag = "R6";
    feed(NT + 3, 0, 1'b1);
    drain();
    chk(vcount == 0, "R6", vcount, 0);
    tag = "R4";
    feed(24, 0, 1'b0);
    drain();
    chk(vcount == 3, "R5", vcount, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule